// File: doc/BRIEF.md
# Synchronous Burst SRAM with Sleep

This block models a small single-port synchronous SRAM. Its 36-bit word is split into four 9-bit byte lanes. Every control, address and write-data input is sampled on the rising clock edge.

An access starts with a begin cycle. The begin cycle loads an external address and fixes whether the burst reads or writes. Continue cycles that follow take their address from a two-bit linear counter, which wraps after four accesses. Read data is registered and comes out one enabled edge after the read cycle. Write data is taken one enabled edge after its address cycle.

A clock-enable input can freeze the whole pipeline for any number of edges. A sleep request first passes through a two-flop synchronizer. It parks the block two edges after it is raised, and releases it two edges after it is lowered. Memory contents survive sleep, but any access still in flight is dropped.

Top module: `burst_sram_sleep`

## Requirements
- R1: After reset, `dout_en` is 0 and `asleep` is 0, and no burst is active.
- R2: An enabled edge with `ce_n`=0, `adv_ld`=0 and `we_n`=1 begins a read burst at `addr`. At the next enabled edge, `dout` carries that word and `dout_en` equals the inverse of the `oe_n` value sampled with the read.
- R3: An enabled edge with `ce_n`=0, `adv_ld`=0 and `we_n`=0 begins a write burst at `addr`. At the next enabled edge, each byte lane i (bits 9i+8 down to 9i) whose `bw_n[i]` was 0 in the address cycle takes the matching lane of `din`. Other lanes keep their contents.
- R4: While a burst is active, an enabled edge with `adv_ld`=1 continues it in the direction fixed at the begin cycle, whatever `we_n` is. Access n of the burst (n = 0 for the begin cycle) uses the begin address with its two low bits replaced by (low bits + n) mod 4. The upper bits stay the same, so the fifth access returns to the start address.
- R5: A write cycle with all four `bw_n` bits at 1 (abort write) changes no memory word, but it still starts or advances the burst.
- R6: A read cycle sampled with `oe_n`=1 (dummy read) gives `dout_en`=0 at the next enabled edge, but it still starts or advances the burst.
- R7: An edge with `cen_n`=1 and no sleep activity changes nothing. `dout_en`, `dout` and all pending accesses hold their values.
- R8: An enabled edge with `ce_n`=1 and `adv_ld`=0 ends the burst. An enabled edge with `adv_ld`=1 and no active burst is a continue-deselect and makes no access. Either cycle gives `dout_en`=0 at the next enabled edge.
- R9: After any write cycle, `dout_en` is 0 at the next enabled edge, whatever `oe_n` is.
- R10: `asleep` rises two edges after `sleep_in` is seen high and falls two edges after it is seen low. From the first edge that sees `sleep_in` high until two edges after it drops, all address and control inputs are ignored and `dout_en` is 0.
- R11: Entering sleep drops any pending write or read, and an active burst ends. Memory contents are kept through sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cen_n | input | 1 | Clock enable, active low; high makes the edge ignored |
| ce_n | input | 1 | Chip enable, active low |
| adv_ld | input | 1 | 0 = begin/deselect with external address, 1 = continue burst |
| we_n | input | 1 | Write enable, active low, sampled at begin cycles |
| bw_n | input | 4 | Per-lane write enables, active low |
| oe_n | input | 1 | Output enable, active low, sampled with read cycles |
| addr | input | AW (6) | Word address |
| din | input | 36 | Write data, taken one enabled edge after its address cycle |
| dout | output | 36 | Registered read data |
| dout_en | output | 1 | Output drive enable (0 stands for high impedance) |
| sleep_in | input | 1 | Asynchronous sleep request |
| asleep | output | 1 | Block is fully in sleep |

## Verification
The assertions assume that `cen_n`, `ce_n` and the other synchronous inputs are stable around the rising edge. They also assume `sleep_in` is stable across the edges it is sampled on, so the two-edge entry and exit latencies are exact. The bench drives every input only at falling edges. It holds `ce_n` inactive around each sleep entry and exit, except in one deliberate case: a write is issued on the same edge that first sees the sleep request, to show that it gets dropped. Before any read, the bench writes every address, so expected read data is never undefined.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int unsigned SBS_LANES  = 4;
  localparam int unsigned SBS_LANE_W = 9;
  localparam int unsigned SBS_DATA_W = SBS_LANES * SBS_LANE_W;

  typedef enum logic [2:0] {
    CYC_NONE,
    CYC_DESEL,
    CYC_BEGIN_RD,
    CYC_BEGIN_WR,
    CYC_CONT_RD,
    CYC_CONT_WR
  } sbs_cyc_e;
endpackage

// File: rtl/sbs_sleep_sync.sv
module sbs_sleep_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_in,
  output logic hold,
  output logic asleep
);
  logic stg1_q, stg2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= 1'b0;
      stg2_q <= 1'b0;
    end else begin
      stg1_q <= sleep_in;
      stg2_q <= stg1_q;
    end
  end

  assign hold   = stg1_q | stg2_q;
  assign asleep = stg2_q;

  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past(sleep_in, 2)); // R10
  AST_SLEEP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep) |-> !$past(sleep_in, 2)); // R10
endmodule

// File: rtl/sbs_burst_ctrl.sv
module sbs_burst_ctrl
  import sbs_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cen_n,
  input  logic                 hold,
  input  logic                 ce_n,
  input  logic                 adv_ld,
  input  logic                 we_n,
  input  logic [SBS_LANES-1:0] bw_n,
  input  logic                 oe_n,
  input  logic [AW-1:0]        addr,
  output logic                 wr_en,
  output logic [SBS_LANES-1:0] wr_be,
  output logic [AW-1:0]        wr_addr,
  output logic                 rd_en,
  output logic [AW-1:0]        rd_addr,
  output logic                 dout_en
);
  logic                 go;
  sbs_cyc_e             cyc;
  logic [AW-1:0]        acc_addr;
  logic                 is_rd, is_wr;

  logic                 active_q, active_d;
  logic                 dir_wr_q, dir_wr_d;
  logic [AW-1:0]        base_q, base_d;
  logic [1:0]           cnt_q, cnt_d;
  logic                 wp_vld_q, wp_vld_d;
  logic [SBS_LANES-1:0] wp_be_q, wp_be_d;
  logic [AW-1:0]        wp_addr_q, wp_addr_d;
  logic                 rp_vld_q, rp_vld_d;
  logic                 rp_oe_q, rp_oe_d;
  logic [AW-1:0]        rp_addr_q, rp_addr_d;
  logic                 den_q, den_d;

  // cycle decode
  always_comb begin
    go = !cen_n && !hold;
    if (!adv_ld && !ce_n)     cyc = we_n ? CYC_BEGIN_RD : CYC_BEGIN_WR;
    else if (!adv_ld)         cyc = CYC_DESEL;
    else if (active_q)        cyc = dir_wr_q ? CYC_CONT_WR : CYC_CONT_RD;
    else                      cyc = CYC_NONE;
    is_rd = (cyc == CYC_BEGIN_RD) || (cyc == CYC_CONT_RD);
    is_wr = (cyc == CYC_BEGIN_WR) || (cyc == CYC_CONT_WR);
    if (cyc == CYC_BEGIN_RD || cyc == CYC_BEGIN_WR)
      acc_addr = addr;
    else
      acc_addr = {base_q[AW-1:2], base_q[1:0] + cnt_q + 2'd1};
  end

  // next state
  always_comb begin
    active_d  = active_q;
    dir_wr_d  = dir_wr_q;
    base_d    = base_q;
    cnt_d     = cnt_q;
    wp_vld_d  = wp_vld_q;
    wp_be_d   = wp_be_q;
    wp_addr_d = wp_addr_q;
    rp_vld_d  = rp_vld_q;
    rp_oe_d   = rp_oe_q;
    rp_addr_d = rp_addr_q;
    den_d     = den_q;
    if (hold) begin
      active_d = 1'b0;
      wp_vld_d = 1'b0;
      rp_vld_d = 1'b0;
      den_d    = 1'b0;
    end else if (go) begin
      den_d = rp_vld_q && rp_oe_q;
      unique case (cyc)
        CYC_BEGIN_RD, CYC_BEGIN_WR: begin
          active_d = 1'b1;
          dir_wr_d = (cyc == CYC_BEGIN_WR);
          base_d   = addr;
          cnt_d    = 2'd0;
        end
        CYC_CONT_RD, CYC_CONT_WR: cnt_d = cnt_q + 2'd1;
        CYC_DESEL:                active_d = 1'b0;
        default:                  ;
      endcase
      wp_vld_d  = is_wr;
      wp_be_d   = ~bw_n;
      wp_addr_d = acc_addr;
      rp_vld_d  = is_rd;
      rp_oe_d   = !oe_n;
      rp_addr_d = acc_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      dir_wr_q  <= 1'b0;
      base_q    <= '0;
      cnt_q     <= 2'd0;
      wp_vld_q  <= 1'b0;
      wp_be_q   <= '0;
      wp_addr_q <= '0;
      rp_vld_q  <= 1'b0;
      rp_oe_q   <= 1'b0;
      rp_addr_q <= '0;
      den_q     <= 1'b0;
    end else begin
      active_q  <= active_d;
      dir_wr_q  <= dir_wr_d;
      base_q    <= base_d;
      cnt_q     <= cnt_d;
      wp_vld_q  <= wp_vld_d;
      wp_be_q   <= wp_be_d;
      wp_addr_q <= wp_addr_d;
      rp_vld_q  <= rp_vld_d;
      rp_oe_q   <= rp_oe_d;
      rp_addr_q <= rp_addr_d;
      den_q     <= den_d;
    end
  end

  assign wr_en   = go && wp_vld_q;
  assign wr_be   = wp_be_q;
  assign wr_addr = wp_addr_q;
  assign rd_en   = go && rp_vld_q;
  assign rd_addr = rp_addr_q;
  assign dout_en = den_q;

  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (go && is_wr) |=> ##1 (!dout_en || $past(cen_n) || $past(hold))); // R9
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cen_n && !hold) |=> $stable(dout_en)); // R7
endmodule

// File: rtl/sbs_byte_array.sv
module sbs_byte_array
  import sbs_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned AW    = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [SBS_LANES-1:0]  wr_be,
  input  logic [AW-1:0]         wr_addr,
  input  logic [SBS_DATA_W-1:0] wr_data,
  input  logic                  rd_en,
  input  logic [AW-1:0]         rd_addr,
  output logic [SBS_DATA_W-1:0] rd_data
);
  for (genvar g = 0; g < SBS_LANES; g++) begin : g_lane
    logic [SBS_LANE_W-1:0] mem [DEPTH];
    logic [SBS_LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (wr_en && wr_be[g]) mem[wr_addr] <= wr_data[g*SBS_LANE_W +: SBS_LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_q <= '0;
      else if (rd_en) rd_q <= mem[rd_addr];
    end

    assign rd_data[g*SBS_LANE_W +: SBS_LANE_W] = rd_q;
  end
endmodule

// File: rtl/burst_sram_sleep.sv
module burst_sram_sleep
  import sbs_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cen_n,
  input  logic                  ce_n,
  input  logic                  adv_ld,
  input  logic                  we_n,
  input  logic [SBS_LANES-1:0]  bw_n,
  input  logic                  oe_n,
  input  logic [AW-1:0]         addr,
  input  logic [SBS_DATA_W-1:0] din,
  output logic [SBS_DATA_W-1:0] dout,
  output logic                  dout_en,
  input  logic                  sleep_in,
  output logic                  asleep
);
  logic                 hold;
  logic                 wr_en, rd_en;
  logic [SBS_LANES-1:0] wr_be;
  logic [AW-1:0]        wr_addr, rd_addr;

  sbs_sleep_sync i_sync (
    .clk(clk), .rst_n(rst_n), .sleep_in(sleep_in), .hold(hold), .asleep(asleep)
  );

  sbs_burst_ctrl #(.AW(AW)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .hold(hold), .ce_n(ce_n),
    .adv_ld(adv_ld), .we_n(we_n), .bw_n(bw_n), .oe_n(oe_n), .addr(addr),
    .wr_en(wr_en), .wr_be(wr_be), .wr_addr(wr_addr), .rd_en(rd_en),
    .rd_addr(rd_addr), .dout_en(dout_en)
  );

  sbs_byte_array #(.DEPTH(DEPTH), .AW(AW)) i_array (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_addr(wr_addr),
    .wr_data(din), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(dout)
  );

  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> !dout_en); // R10
  AST_NO_WRITE_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> !wr_en); // R11
  AST_STALL_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (cen_n && !hold) |=> $stable(dout)); // R7
endmodule

// File: tb/test_burst_sram_sleep.sv
module test_burst_sram_sleep;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cen_n, ce_n, adv_ld, we_n, oe_n, sleep_in;
  logic [3:0]  bw_n;
  logic [5:0]  addr;
  logic [35:0] din;
  logic [35:0] dout;
  logic        dout_en, asleep;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit cmp_on = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_sram_sleep #(.DEPTH(DEPTH)) i_burst_sram_sleep (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .ce_n(ce_n), .adv_ld(adv_ld),
    .we_n(we_n), .bw_n(bw_n), .oe_n(oe_n), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en), .sleep_in(sleep_in), .asleep(asleep)
  );

  // behavioural reference
  logic [35:0] mm [DEPTH];
  bit          s1, s2, m_en, b_act, b_wr;
  logic [35:0] m_dout;
  int          b_base, b_off;
  bit          p_rd, p_oe, p_wr;
  int          p_ra, p_wa;
  logic [3:0]  p_be;

  always @(posedge clk) begin
    if (!rst_n) begin
      s1 = 0; s2 = 0; m_en = 0; b_act = 0; p_rd = 0; p_wr = 0;
    end else begin
      bit hold;
      hold = s1 | s2;
      if (hold) begin
        m_en = 0; p_rd = 0; p_wr = 0; b_act = 0;
      end else if (!cen_n) begin
        int a;
        bit nrd, nwr;
        m_en = p_rd && p_oe;
        if (p_rd && p_oe) m_dout = mm[p_ra];
        if (p_wr)
          for (int i = 0; i < 4; i++)
            if (p_be[i]) mm[p_wa][i*9 +: 9] = din[i*9 +: 9];
        nrd = 0; nwr = 0; a = 0;
        if (!adv_ld && !ce_n) begin
          b_act = 1; b_wr = !we_n; b_base = int'(addr); b_off = 0;
          a = b_base; nwr = b_wr; nrd = !b_wr;
        end else if (!adv_ld) begin
          b_act = 0;
        end else if (b_act) begin
          b_off = (b_off + 1) % 4;
          a = (b_base / 4) * 4 + ((b_base % 4) + b_off) % 4;
          nwr = b_wr; nrd = !b_wr;
        end
        p_rd = nrd; p_oe = !oe_n; p_ra = a;
        p_wr = nwr; p_be = ~bw_n; p_wa = a;
      end
      s2 = s1; s1 = sleep_in;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      checks++;
      if (dout_en !== m_en || asleep !== s2 || (m_en && dout !== m_dout)) begin
        errors++;
        $display("FAIL %s: dout_en=%0b asleep=%0b dout=%h expected dout_en=%0b asleep=%0b dout=%h",
                 cur_req, dout_en, asleep, dout, m_en, s2, m_dout);
      end
    end
  end

  function automatic logic [35:0] pat(input int a);
    return 36'(a * 36'h0_0F0F1 + 36'h1_2345_6789);
  endfunction

  task automatic cyc(input logic c, input logic adv, input logic w,
                     input logic [3:0] b, input logic o, input int ad,
                     input logic [35:0] d);
    ce_n = c; adv_ld = adv; we_n = w; bw_n = b; oe_n = o;
    addr = 6'(ad); din = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic direct(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; cen_n = 0; ce_n = 1; adv_ld = 0; we_n = 1; bw_n = 4'hF;
    oe_n = 0; addr = 0; din = 0; sleep_in = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    direct("R1", dout_en, 1'b0);
    direct("R1", asleep, 1'b0);
    rst_n = 1;
    cmp_on = 1;

    // R3 / R4: preload every word with 4-beat write bursts, data one cycle late
    cur_req = "R3";
    for (int a = 0; a < DEPTH; a++)
      cyc(0, (a % 4) != 0, 0, 4'h0, 0, a, (a == 0) ? 36'h0 : pat(a - 1));
    cyc(1, 0, 1, 4'hF, 0, 0, pat(DEPTH - 1));

    // R2 single reads
    cur_req = "R2";
    for (int k = 0; k < 5; k++) cyc(0, 0, 1, 4'hF, 0, k * 13 % DEPTH, 0);
    cyc(1, 0, 1, 4'hF, 0, 0, 0);

    // R4 read burst starting mid-group, six beats to show wrap
    cur_req = "R4";
    cyc(0, 0, 1, 4'hF, 0, 22, 0);
    for (int k = 0; k < 5; k++) cyc(1, 1, 0, 4'h0, 0, 0, 0);
    // R4 write burst with partial lanes, direction fixed at begin
    cyc(0, 0, 0, 4'hE, 0, 41, 0);
    cyc(1, 1, 1, 4'h5, 1, 0, 36'hA_AAAA_AAAA);
    cyc(1, 1, 1, 4'h3, 0, 0, 36'h5_5555_5555);
    cyc(1, 0, 1, 4'hF, 0, 0, 36'hC_3C3C_3C3C);
    for (int k = 40; k < 44; k++) cyc(0, 0, 1, 4'hF, 0, k, 0);

    // R5 abort write then read back
    cur_req = "R5";
    cyc(0, 0, 0, 4'hF, 0, 9, 0);
    cyc(1, 1, 0, 4'hF, 0, 0, 36'hF_FFFF_FFFF);
    cyc(0, 0, 1, 4'hF, 0, 9, 36'hF_FFFF_FFFF);
    cyc(0, 0, 1, 4'hF, 0, 10, 0);

    // R6 dummy read burst
    cur_req = "R6";
    cyc(0, 0, 1, 4'hF, 1, 30, 0);
    cyc(1, 1, 1, 4'hF, 1, 0, 0);
    cyc(1, 1, 1, 4'hF, 0, 0, 0);
    cyc(1, 0, 1, 4'hF, 0, 0, 0);

    // R7 stalls after read and after write
    cur_req = "R7";
    cyc(0, 0, 1, 4'hF, 0, 17, 0);
    cen_n = 1;
    for (int k = 0; k < 3; k++) cyc(0, 0, 0, 4'h0, 0, 5, 36'h1);
    cen_n = 0;
    cyc(0, 0, 0, 4'h0, 0, 17, 0);
    cen_n = 1;
    cyc(0, 0, 1, 4'hF, 0, 3, 36'h2);
    cen_n = 0;
    cyc(0, 0, 1, 4'hF, 0, 17, 36'h7_7777_7777);
    cyc(1, 0, 1, 4'hF, 0, 0, 0);

    // R8 deselect and continue-deselect
    cur_req = "R8";
    cyc(0, 0, 1, 4'hF, 0, 50, 0);
    cyc(1, 0, 1, 4'hF, 0, 0, 0);
    cyc(0, 1, 0, 4'h0, 0, 0, 36'h3);
    cyc(1, 1, 0, 4'h0, 0, 0, 36'h4);
    cyc(0, 0, 1, 4'hF, 0, 50, 0);
    cyc(1, 0, 1, 4'hF, 0, 0, 0);

    // R9 write cycle with output enable asserted
    cur_req = "R9";
    cyc(0, 0, 1, 4'hF, 0, 60, 0);
    cyc(0, 0, 0, 4'h0, 0, 61, 0);
    cyc(1, 0, 1, 4'hF, 0, 0, 36'h9_0909_0909);
    cyc(0, 0, 1, 4'hF, 0, 61, 0);
    cyc(1, 0, 1, 4'hF, 0, 0, 0);

    // R10 sleep entry and exit with inputs toggling
    cur_req = "R10";
    sleep_in = 1;
    cyc(1, 0, 1, 4'hF, 0, 0, 0);
    direct("R10", asleep, 1'b0);
    cyc(1, 0, 1, 4'hF, 0, 0, 0);
    direct("R10", asleep, 1'b1);
    for (int k = 0; k < 4; k++) cyc(0, 0, 0, 4'h0, 0, 2, 36'hD_EAD0_0000);
    cyc(1, 0, 1, 4'hF, 0, 0, 0);
    sleep_in = 0;
    cyc(1, 0, 1, 4'hF, 0, 0, 0);
    direct("R10", asleep, 1'b1);
    cyc(1, 0, 1, 4'hF, 0, 0, 0);
    direct("R10", asleep, 1'b0);
    cyc(0, 0, 1, 4'hF, 0, 2, 0);
    cyc(1, 0, 1, 4'hF, 0, 0, 0);

    // R11 write caught by sleep entry is dropped
    cur_req = "R11";
    sleep_in = 1;
    cyc(0, 0, 0, 4'h0, 0, 12, 0);
    cyc(1, 0, 1, 4'hF, 0, 0, 36'hB_AD00_BAD0);
    repeat (3) cyc(1, 0, 1, 4'hF, 0, 0, 0);
    sleep_in = 0;
    repeat (3) cyc(1, 0, 1, 4'hF, 0, 0, 0);
    cyc(0, 0, 1, 4'hF, 0, 12, 0);
    cyc(1, 0, 1, 4'hF, 0, 0, 0);

    // mixed traffic across R2 and R4
    cur_req = "R4";
    for (int k = 0; k < 300; k++) begin
      int r;
      r = $urandom_range(0, 9);
      cen_n = (r == 0);
      cyc((r == 1), (r > 5), 1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)),
          1'(r == 2), $urandom_range(0, DEPTH - 1), {4'h0, 32'($urandom)});
    end
    cen_n = 0;
    cyc(1, 0, 1, 4'hF, 0, 0, 0);
    cyc(1, 0, 1, 4'hF, 0, 0, 0);
    finish_run();
  end
endmodule